// File: doc/BRIEF.md
# ALU Operation Select Decoder

This block sits between the main instruction controller and the arithmetic/logic unit of a single-cycle datapath. The controller summarises each instruction as a 2-bit class code. The decoder combines that class with the 6-bit function field of the instruction word and produces the 4-bit operation select that steers the ALU.

Memory-access and branch-equal classes force a fixed operation, and the function field is ignored for them. The register-register class passes control to the function field, which is decoded into one of six ALU operations. The reserved class code and any function field the decoder does not know raise an invalid-operation flag. The decoder also emits a safe default select in those cases, so the datapath never sees an undefined code.

The block is purely combinational. It has no clock and no reset, and its outputs follow its inputs within the same cycle.

Top module: `aluop_decoder`

## Requirements
- R1: With class code 00 (memory access) the select is 0010 (add) and the flag is low, for all 64 function field values.
- R2: With class code 01 (branch-equal) the select is 0110 (subtract) and the flag is low, for all 64 function field values.
- R3: With class code 10, function 100000 gives 0010 (add) and function 100010 gives 0110 (subtract), with the flag low.
- R4: With class code 10, function 100100 gives 0000 (AND) and function 100101 gives 0001 (OR), with the flag low.
- R5: With class code 10, function 101010 gives 0111 (set-on-less-than), with the flag low.
- R6: With class code 10, function 100111 gives 1100 (NOR), with the flag low.
- R7: With class code 11 the select is 0010 (add) and the flag is high, for any function field.
- R8: With class code 10 and a function field not listed in R3 to R6, the select is 0000 (AND) and the flag is high.
- R9: Both outputs are combinational: they reflect the present inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Instruction class code from the main controller |
| funct | input | 6 | Function field of the current instruction word |
| alu_sel | output | 4 | Operation select driven to the ALU |
| bad_op | output | 1 | High when the class or function field is not recognised |

## Verification
Every result of this decoder is due zero cycles after its stimulus, because no register lies between the inputs and the outputs. The driver applies a class and function pair just after a rising edge and queues the expected select and flag. The monitor pops and compares that entry at the following falling edge, inside the same cycle, after the combinational path has settled. Each queued entry is consumed before the next stimulus is applied.

// File: rtl/aluop_pkg.sv
package aluop_pkg;

    localparam int CLS_W = 2;
    localparam int FN_W  = 6;
    localparam int SEL_W = 4;
    localparam int N_FN  = 6;

    localparam logic [CLS_W-1:0] CLS_MEM = 2'b00;
    localparam logic [CLS_W-1:0] CLS_BR  = 2'b01;
    localparam logic [CLS_W-1:0] CLS_REG = 2'b10;
    localparam logic [CLS_W-1:0] CLS_RSV = 2'b11;

    localparam logic [SEL_W-1:0] SEL_AND = 4'b0000;
    localparam logic [SEL_W-1:0] SEL_OR  = 4'b0001;
    localparam logic [SEL_W-1:0] SEL_ADD = 4'b0010;
    localparam logic [SEL_W-1:0] SEL_SUB = 4'b0110;
    localparam logic [SEL_W-1:0] SEL_SLT = 4'b0111;
    localparam logic [SEL_W-1:0] SEL_NOR = 4'b1100;

    // Function codes recognised in the register class and their selects.
    localparam logic [FN_W-1:0] FN_TAB [N_FN] = '{
        6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010, 6'b100111
    };
    localparam logic [SEL_W-1:0] SEL_TAB [N_FN] = '{
        SEL_ADD, SEL_SUB, SEL_AND, SEL_OR, SEL_SLT, SEL_NOR
    };

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             bad;
    } dec_t;

endpackage

// File: rtl/aluop_class_dec.sv
module aluop_class_dec
    import aluop_pkg::*;
#(
    parameter int CW = CLS_W,
    parameter int SW = SEL_W
) (
    input  logic [CW-1:0] op_class,
    output logic [SW-1:0] force_sel,
    output logic          use_fn,
    output logic          rsv
);

    always_comb begin
        force_sel = SEL_ADD;
        use_fn    = 1'b0;
        rsv       = 1'b0;
        case (op_class)
            CLS_MEM: force_sel = SEL_ADD;
            CLS_BR:  force_sel = SEL_SUB;
            CLS_REG: use_fn    = 1'b1;
            default: rsv       = 1'b1;
        endcase
    end

    always_comb begin
        if (!$isunknown(op_class))
            AST_CLASS_EXCL: assert (!(use_fn && rsv)); // R7
    end

endmodule

// File: rtl/aluop_funct_dec.sv
module aluop_funct_dec
    import aluop_pkg::*;
#(
    parameter int FW = FN_W,
    parameter int SW = SEL_W,
    parameter int NF = N_FN
) (
    input  logic [FW-1:0] funct,
    output logic [SW-1:0] fn_sel,
    output logic          fn_hit
);

    logic [NF-1:0] match;
    logic [SW-1:0] part [NF];

    generate
        for (genvar i = 0; i < NF; i++) begin : g_fn
            assign match[i] = (funct == FN_TAB[i]);
            assign part[i]  = match[i] ? SEL_TAB[i] : '0;
        end
    endgenerate

    // A miss leaves the OR-reduction at zero, which is the AND select.
    always_comb begin
        fn_sel = SEL_AND;
        fn_hit = |match;
        for (int i = 0; i < NF; i++) fn_sel = fn_sel | part[i];
    end

    always_comb begin
        if (!$isunknown(funct))
            AST_SINGLE_MATCH: assert ($onehot0(match)); // R8
    end

endmodule

// File: rtl/aluop_decoder.sv
module aluop_decoder
    import aluop_pkg::*;
#(
    parameter int CW = CLS_W,
    parameter int FW = FN_W,
    parameter int SW = SEL_W
) (
    input  logic [CW-1:0] op_class,
    input  logic [FW-1:0] funct,
    output logic [SW-1:0] alu_sel,
    output logic          bad_op
);

    logic [SW-1:0] force_sel;
    logic          use_fn;
    logic          rsv;
    logic [SW-1:0] fn_sel;
    logic          fn_hit;
    dec_t          dec_d;

    aluop_class_dec #(.CW(CW), .SW(SW)) u_cls (
        .op_class (op_class),
        .force_sel(force_sel),
        .use_fn   (use_fn),
        .rsv      (rsv)
    );

    aluop_funct_dec #(.FW(FW), .SW(SW), .NF(N_FN)) u_fn (
        .funct (funct),
        .fn_sel(fn_sel),
        .fn_hit(fn_hit)
    );

    always_comb begin
        dec_d.sel = force_sel;
        dec_d.bad = rsv;
        if (use_fn) begin
            dec_d.sel = fn_sel;
            dec_d.bad = !fn_hit;
        end
    end

    assign alu_sel = dec_d.sel;
    assign bad_op  = dec_d.bad;

    always_comb begin
        if (op_class == CLS_MEM)
            AST_MEM_ADD: assert (alu_sel == SEL_ADD && !bad_op); // R1
        if (op_class == CLS_BR)
            AST_BR_SUB: assert (alu_sel == SEL_SUB && !bad_op); // R2
        if (op_class == CLS_RSV)
            AST_RSV_FLAG: assert (alu_sel == SEL_ADD && bad_op); // R7
        if (op_class == CLS_REG && bad_op === 1'b1)
            AST_UNKNOWN_AND: assert (alu_sel == SEL_AND); // R8
        if (op_class == CLS_REG && funct == 6'b100111)
            AST_NOR_SEL: assert (alu_sel == SEL_NOR && !bad_op); // R6
    end

endmodule

// File: tb/aluop_decoder_test.sv
`timescale 1ns/1ps
module aluop_decoder_test;

    logic       clk = 1'b0;
    logic [1:0] op_class = 2'b00;
    logic [5:0] funct = 6'b000000;
    logic [3:0] alu_sel;
    logic       bad_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] sel;
        logic       bad;
        string      req;
    } exp_t;

    exp_t sb [$];

    always #2 clk = ~clk;

    aluop_decoder uut (
        .op_class(op_class),
        .funct   (funct),
        .alu_sel (alu_sel),
        .bad_op  (bad_op)
    );

    // Expected values taken from the requirement list.
    function automatic exp_t model(input logic [1:0] c, input logic [5:0] f);
        exp_t e;
        e.bad = 1'b0;
        case (c)
            2'b00: begin e.sel = 4'b0010; e.req = "R1"; end
            2'b01: begin e.sel = 4'b0110; e.req = "R2"; end
            2'b11: begin e.sel = 4'b0010; e.bad = 1'b1; e.req = "R7"; end
            default: begin
                case (f)
                    6'b100000: begin e.sel = 4'b0010; e.req = "R3"; end
                    6'b100010: begin e.sel = 4'b0110; e.req = "R3"; end
                    6'b100100: begin e.sel = 4'b0000; e.req = "R4"; end
                    6'b100101: begin e.sel = 4'b0001; e.req = "R4"; end
                    6'b101010: begin e.sel = 4'b0111; e.req = "R5"; end
                    6'b100111: begin e.sel = 4'b1100; e.req = "R6"; end
                    default:   begin e.sel = 4'b0000; e.bad = 1'b1; e.req = "R8"; end
                endcase
            end
        endcase
        return e;
    endfunction

    task automatic drive(input logic [1:0] c, input logic [5:0] f);
        @(posedge clk);
        op_class = c;
        funct    = f;
        sb.push_back(model(c, f));
    endtask

    // Monitor: results are due in the same cycle (R9), sampled at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (alu_sel !== e.sel || bad_op !== e.bad) begin
                errors++;
                $display("FAIL %s R9 class=%b funct=%b actual sel=%b bad=%b expected sel=%b bad=%b",
                         e.req, op_class, funct, alu_sel, bad_op, e.sel, e.bad);
            end
        end
    end

    initial begin
        logic [5:0] listed [10];
        listed = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010,
                   6'b100111, 6'b000000, 6'b111111, 6'b100001, 6'b101011};
        // Idle inputs: class 00 with zero function field (R1).
        drive(2'b00, 6'b000000);
        // R1, R2: function field ignored for forced classes.
        for (int f = 0; f < 64; f++) drive(2'b00, f[5:0]);
        for (int f = 0; f < 64; f++) drive(2'b01, f[5:0]);
        // R3..R8: every class against listed and unlisted function codes.
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 10; k++) drive(c[1:0], listed[k]);
        // R8: whole function space in the register class.
        for (int f = 0; f < 64; f++) drive(2'b10, f[5:0]);
        // R7: reserved class with a recognised code.
        drive(2'b11, 6'b100010);
        // R9: back-to-back changes, each checked in its own cycle.
        drive(2'b10, 6'b100111);
        drive(2'b01, 6'b100111);
        drive(2'b10, 6'b101010);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule